// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides which message buffer, if any, accepts a received frame identifier. Every buffer holds a programmed 32-bit identifier word and an active bit. A received identifier is compared with all buffers in one pass. Each comparison goes through a mask: a mask bit of 1 means that bit must agree with the buffer's identifier, and a mask bit of 0 means that bit is ignored. The result is a hit flag and the number of the lowest-numbered buffer that accepted the frame.

The mask for each buffer is chosen by a scheme bit. In the shared-mask scheme, one common mask serves almost every buffer, but two designated buffers (14 and 15 by default) each take a mask of their own. In the per-buffer scheme, every buffer has its own mask. The frame receiver raises a one-cycle strobe together with the identifier. The registered result appears on the next clock edge, marked by a one-cycle result-valid pulse, and it holds until the next strobe.

Top module: `can_id_filter`

## Requirements
- R1: While reset is asserted and right after it, `res_valid`, `hit` and `hit_idx` are all 0.
- R2: A buffer accepts an identifier exactly when `((rx_id ^ buffer_id) & mask) == 0`. Mask bits at 1 must agree, and mask bits at 0 are ignored.
- R3: With `ind_mode` = 0 (shared scheme), every buffer other than the two designated ones is filtered with `glob_mask`.
- R4: With `ind_mode` = 0, buffer `LEG_A` (default 14) is filtered with `ded_mask_a`, and buffer `LEG_B` (default 15) is filtered with `ded_mask_b`. `glob_mask` does not apply to either of them.
- R5: With `ind_mode` = 1 (per-buffer scheme), buffer i is filtered with `ind_mask_flat[i*32 +: 32]`. `glob_mask`, `ded_mask_a` and `ded_mask_b` have no effect.
- R6: A buffer whose `buf_active` bit is 0 never accepts, whatever its identifier and mask.
- R7: When several buffers accept, `hit` is 1 and `hit_idx` is the lowest-numbered accepting buffer. The index range runs from 0 to 63.
- R8: The clock edge that samples `rx_valid` = 1 updates `hit` and `hit_idx` and sets `res_valid` to 1 for one cycle. Edges without a strobe clear `res_valid` and leave `hit` and `hit_idx` unchanged.
- R9: When no buffer accepts, `hit` is 0 and `hit_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Single-cycle strobe qualifying `rx_id` |
| rx_id | input | 32 | Received identifier word |
| ind_mode | input | 1 | Mask scheme: 0 shared, 1 per-buffer |
| glob_mask | input | 32 | Common mask for the shared scheme |
| ded_mask_a | input | 32 | Mask of buffer LEG_A in the shared scheme |
| ded_mask_b | input | 32 | Mask of buffer LEG_B in the shared scheme |
| ind_mask_flat | input | 2048 | Per-buffer masks, buffer i at bits [i*32 +: 32] |
| buf_id_flat | input | 2048 | Buffer identifiers, buffer i at bits [i*32 +: 32] |
| buf_active | input | 64 | Active bit per buffer |
| res_valid | output | 1 | One-cycle pulse marking a fresh result |
| hit | output | 1 | At least one buffer accepted the identifier |
| hit_idx | output | 6 | Lowest accepting buffer, 0 when none |

## Verification
The assertions check the timing on every cycle. Each strobe is followed by exactly one result pulse, and the outputs stay still between strobes. A miss always reports index 0. The assertions also check the result against the internal match vector: the hit flag equals the OR of that vector, the reported buffer is set in it, no lower buffer is set, and the reported buffer was active. Only the bench scenarios can show that the right mask went to each buffer. These scenarios cover the two designated buffers in the shared scheme, the switch to per-buffer masks, the don't-care bits, and that the masks of the unused scheme are ignored. Buffer 0, buffer 63 and the full-miss case are also covered only by the bench.

// File: rtl/can_filt_pkg.sv
`timescale 1ns/1ps
package can_filt_pkg;

  localparam int unsigned DEF_NUM_BUF = 64;
  localparam int unsigned DEF_ID_W    = 32;
  localparam int unsigned DEF_LEG_A   = 14;
  localparam int unsigned DEF_LEG_B   = 15;

  typedef enum logic {
    MASK_SHARED = 1'b0,
    MASK_INDIV  = 1'b1
  } mask_mode_e;

endpackage

// File: rtl/can_filt_mask_sel.sv
`timescale 1ns/1ps
module can_filt_mask_sel
  import can_filt_pkg::*;
#(
  parameter int unsigned NUM_BUF = DEF_NUM_BUF,
  parameter int unsigned ID_W    = DEF_ID_W,
  parameter int unsigned LEG_A   = DEF_LEG_A,
  parameter int unsigned LEG_B   = DEF_LEG_B
) (
  input  mask_mode_e                 mode,
  input  logic [ID_W-1:0]            glob_mask,
  input  logic [ID_W-1:0]            ded_mask_a,
  input  logic [ID_W-1:0]            ded_mask_b,
  input  logic [NUM_BUF*ID_W-1:0]    ind_mask_flat,
  output logic [NUM_BUF*ID_W-1:0]    eff_mask_flat
);

  // Choose between the shared-scheme mask and the buffer's own mask.
  function automatic logic [ID_W-1:0] pick_mask(
    input mask_mode_e      m,
    input logic [ID_W-1:0] shared_m,
    input logic [ID_W-1:0] own_m
  );
    return (m == MASK_INDIV) ? own_m : shared_m;
  endfunction

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    logic [ID_W-1:0] shared_m;

    // Which mask serves a buffer in the shared scheme is fixed per index.
    if (i == LEG_A) begin : g_leg_a
      assign shared_m = ded_mask_a;
    end else if (i == LEG_B) begin : g_leg_b
      assign shared_m = ded_mask_b;
    end else begin : g_common
      assign shared_m = glob_mask;
    end

    assign eff_mask_flat[i*ID_W +: ID_W] =
      pick_mask(mode, shared_m, ind_mask_flat[i*ID_W +: ID_W]);
  end

endmodule

// File: rtl/can_filt_cmp_bank.sv
`timescale 1ns/1ps
module can_filt_cmp_bank
  import can_filt_pkg::*;
#(
  parameter int unsigned NUM_BUF = DEF_NUM_BUF,
  parameter int unsigned ID_W    = DEF_ID_W
) (
  input  logic [ID_W-1:0]         rx_id,
  input  logic [NUM_BUF*ID_W-1:0] buf_id_flat,
  input  logic [NUM_BUF*ID_W-1:0] eff_mask_flat,
  input  logic [NUM_BUF-1:0]      buf_active,
  output logic [NUM_BUF-1:0]      match_vec
);

  // Masked equality: every bit under a 1 in the mask must agree.
  function automatic logic id_accept(
    input logic [ID_W-1:0] rx,
    input logic [ID_W-1:0] bid,
    input logic [ID_W-1:0] mask
  );
    return ((rx ^ bid) & mask) == '0;
  endfunction

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_cmp
    assign match_vec[i] = buf_active[i] &
      id_accept(rx_id, buf_id_flat[i*ID_W +: ID_W], eff_mask_flat[i*ID_W +: ID_W]);
  end

endmodule

// File: rtl/can_filt_prio.sv
`timescale 1ns/1ps
module can_filt_prio
  import can_filt_pkg::*;
#(
  parameter int unsigned NUM_BUF = DEF_NUM_BUF,
  localparam int unsigned IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic [NUM_BUF-1:0] match_vec,
  output logic               any_hit,
  output logic [IDX_W-1:0]   win_idx
);

  // Lowest set bit; zero when nothing is set.
  function automatic logic [IDX_W-1:0] lowest_set(input logic [NUM_BUF-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign any_hit = |match_vec;
  assign win_idx = lowest_set(match_vec);

endmodule

// File: rtl/can_id_filter.sv
`timescale 1ns/1ps
module can_id_filter
  import can_filt_pkg::*;
#(
  parameter int unsigned NUM_BUF = DEF_NUM_BUF,
  parameter int unsigned ID_W    = DEF_ID_W,
  parameter int unsigned LEG_A   = DEF_LEG_A,
  parameter int unsigned LEG_B   = DEF_LEG_B,
  localparam int unsigned IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int unsigned FLAT_W = NUM_BUF * ID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [ID_W-1:0]   rx_id,
  input  logic              ind_mode,
  input  logic [ID_W-1:0]   glob_mask,
  input  logic [ID_W-1:0]   ded_mask_a,
  input  logic [ID_W-1:0]   ded_mask_b,
  input  logic [FLAT_W-1:0] ind_mask_flat,
  input  logic [FLAT_W-1:0] buf_id_flat,
  input  logic [NUM_BUF-1:0] buf_active,
  output logic              res_valid,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);

  mask_mode_e        mode;
  logic [FLAT_W-1:0] eff_mask_flat;
  logic [NUM_BUF-1:0] match_vec;
  logic              any_hit;
  logic [IDX_W-1:0]  win_idx;
  logic              capture;

  assign mode    = mask_mode_e'(ind_mode);
  assign capture = rx_valid;

  can_filt_mask_sel #(
    .NUM_BUF (NUM_BUF),
    .ID_W    (ID_W),
    .LEG_A   (LEG_A),
    .LEG_B   (LEG_B)
  ) u_mask_sel (
    .mode          (mode),
    .glob_mask     (glob_mask),
    .ded_mask_a    (ded_mask_a),
    .ded_mask_b    (ded_mask_b),
    .ind_mask_flat (ind_mask_flat),
    .eff_mask_flat (eff_mask_flat)
  );

  can_filt_cmp_bank #(
    .NUM_BUF (NUM_BUF),
    .ID_W    (ID_W)
  ) u_cmp (
    .rx_id         (rx_id),
    .buf_id_flat   (buf_id_flat),
    .eff_mask_flat (eff_mask_flat),
    .buf_active    (buf_active),
    .match_vec     (match_vec)
  );

  can_filt_prio #(
    .NUM_BUF (NUM_BUF)
  ) u_prio (
    .match_vec (match_vec),
    .any_hit   (any_hit),
    .win_idx   (win_idx)
  );

  // Result register: the strobe loads, idle cycles hold.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      hit       <= 1'b0;
      hit_idx   <= '0;
    end else begin
      res_valid <= capture;
      if (capture) begin
        hit     <= any_hit;
        hit_idx <= win_idx;
      end
    end
  end

endmodule

// File: rtl/can_id_filter_chk.sv
`timescale 1ns/1ps
module can_id_filter_chk #(
  parameter int unsigned NUM_BUF = 64,
  localparam int unsigned IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rx_valid,
  input logic [NUM_BUF-1:0] buf_active,
  input logic [NUM_BUF-1:0] match_vec,
  input logic               res_valid,
  input logic               hit,
  input logic [IDX_W-1:0]   hit_idx
);

  localparam logic [NUM_BUF-1:0] ONE = {{(NUM_BUF-1){1'b0}}, 1'b1};

  logic [NUM_BUF-1:0] below_idx;
  assign below_idx = (ONE << hit_idx) - ONE;

  a_r8_pulse_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> res_valid);

  a_r8_no_pulse_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !res_valid);

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> ($stable(hit) && $stable(hit_idx)));

  a_r9_miss_reports_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !hit) |-> (hit_idx == '0));

  a_r7_flag_tracks_matches: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> (hit == (|$past(match_vec))));

  a_r7_winner_is_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> (!hit || ((($past(match_vec) >> hit_idx) & ONE) != '0
                           && ($past(match_vec) & below_idx) == '0)));

  a_r6_winner_was_active: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> (!hit || ((($past(buf_active) >> hit_idx) & ONE) != '0)));

  a_r6_inactive_never_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (match_vec & ~buf_active) == '0);

endmodule

bind can_id_filter can_id_filter_chk #(
  .NUM_BUF (NUM_BUF)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_valid   (rx_valid),
  .buf_active (buf_active),
  .match_vec  (match_vec),
  .res_valid  (res_valid),
  .hit        (hit),
  .hit_idx    (hit_idx)
);

// File: tb/sim_can_id_filter.sv
`timescale 1ns/1ps
module sim_can_id_filter;

  localparam int NB = 64;
  localparam int IW = 32;

  localparam logic [63:0] ALL  = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] NO5  = 64'hFFFF_FFFF_FFFF_FFDF;
  localparam logic [63:0] NO63 = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] NONE = 64'h0;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            rx_valid = 1'b0;
  logic [IW-1:0]   rx_id = '0;
  logic            ind_mode = 1'b0;
  logic [IW-1:0]   glob_mask = 32'hFFFF_FFFF;
  logic [IW-1:0]   ded_mask_a = 32'hFFFF_F000;
  logic [IW-1:0]   ded_mask_b = 32'hF000_0000;
  logic [NB*IW-1:0] ind_mask_flat = '0;
  logic [NB*IW-1:0] buf_id_flat = '0;
  logic [NB-1:0]   buf_active = '0;
  logic            res_valid;
  logic            hit;
  logic [5:0]      hit_idx;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 20 ns period, 50 MHz

  can_id_filter u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_id         (rx_id),
    .ind_mode      (ind_mode),
    .glob_mask     (glob_mask),
    .ded_mask_a    (ded_mask_a),
    .ded_mask_b    (ded_mask_b),
    .ind_mask_flat (ind_mask_flat),
    .buf_id_flat   (buf_id_flat),
    .buf_active    (buf_active),
    .res_valid     (res_valid),
    .hit           (hit),
    .hit_idx       (hit_idx)
  );

  typedef struct packed {
    logic        ind;
    logic [63:0] act;
    logic [31:0] rx;
    logic        eh;
    logic [5:0]  ei;
    logic [7:0]  req;
  } vec_t;

  // Buffer i holds {i, 24'h005A5A}. Shared scheme: common mask all ones,
  // buffer 14 checks bits [31:12], buffer 15 checks bits [31:28].
  // Per-buffer scheme: buffers 0..31 all ones, 32..63 check bits [31:24].
  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, ALL,  32'h2000_5A5A, 1'b1, 6'd32, 8'd3},  // R3 common mask
    '{1'b0, ALL,  32'h0E00_5123, 1'b1, 6'd14, 8'd4},  // R4 buffer 14 mask
    '{1'b0, ALL,  32'h0ABC_DEF0, 1'b1, 6'd15, 8'd4},  // R4 buffer 15 mask
    '{1'b0, ALL,  32'h0500_5A5A, 1'b1, 6'd5,  8'd7},  // R7 5 beats 15
    '{1'b0, ALL,  32'h3F00_5A5A, 1'b1, 6'd63, 8'd7},  // R7 top buffer
    '{1'b0, ALL,  32'h0000_5A5A, 1'b1, 6'd0,  8'd7},  // R7 buffer 0
    '{1'b0, ALL,  32'h4000_5A5A, 1'b0, 6'd0,  8'd9},  // R9 full miss
    '{1'b0, ALL,  32'h2000_5A5B, 1'b0, 6'd0,  8'd2},  // R2 one masked bit off
    '{1'b1, ALL,  32'h0ABC_DEF0, 1'b0, 6'd0,  8'd5},  // R5 15 now full mask
    '{1'b1, ALL,  32'h0E00_5123, 1'b0, 6'd0,  8'd5},  // R5 14 now full mask
    '{1'b1, ALL,  32'h2AFF_FFFF, 1'b1, 6'd42, 8'd2},  // R2 don't-care bits
    '{1'b1, ALL,  32'h2000_5A5A, 1'b1, 6'd32, 8'd5},  // R5
    '{1'b1, ALL,  32'h0700_5A5A, 1'b1, 6'd7,  8'd5},  // R5
    '{1'b0, NO5,  32'h0500_5A5A, 1'b1, 6'd15, 8'd6},  // R6 skip inactive 5
    '{1'b1, NONE, 32'h0000_5A5A, 1'b0, 6'd0,  8'd6},  // R6 nothing active
    '{1'b1, NO63, 32'h3FAA_AAAA, 1'b0, 6'd0,  8'd6},  // R6 63 inactive
    '{1'b1, NO63, 32'h3E12_3456, 1'b1, 6'd62, 8'd2}   // R2
  };

  task automatic check(input int req, input string what,
                       input logic ev, input logic eh, input logic [5:0] ei);
    n_chk++;
    if (res_valid !== ev || hit !== eh || hit_idx !== ei) begin
      n_fail++;
      $display("FAIL R%0d %s: actual valid=%0b hit=%0b idx=%0d expected valid=%0b hit=%0b idx=%0d",
               req, what, res_valid, hit, hit_idx, ev, eh, ei);
    end
  endtask

  // Drive one strobe at a falling edge; the result is sampled at the next one.
  task automatic strobe(input logic ind, input logic [63:0] act, input logic [31:0] rx);
    ind_mode   = ind;
    buf_active = act;
    rx_id      = rx;
    rx_valid   = 1'b1;
    @(negedge clk);
    rx_valid   = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin
      buf_id_flat[i*IW +: IW]   = {8'(i), 24'h00_5A5A};
      ind_mask_flat[i*IW +: IW] = (i < 32) ? 32'hFFFF_FFFF : 32'hFF00_0000;
    end

    // R1: outputs cleared during reset, even with a strobe present
    repeat (2) @(negedge clk);
    rx_valid = 1'b1;
    rx_id    = 32'h0000_5A5A;
    buf_active = ALL;
    @(negedge clk);
    check(1, "in reset", 1'b0, 1'b0, 6'd0);
    rx_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(1, "after release", 1'b0, 1'b0, 6'd0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      strobe(VEC[v].ind, VEC[v].act, VEC[v].rx);
      check(int'(VEC[v].req), $sformatf("vector %0d", v), 1'b1, VEC[v].eh, VEC[v].ei);
    end

    // R8: hold with no strobe while inputs move
    strobe(1'b0, ALL, 32'h2000_5A5A);
    check(8, "load 32", 1'b1, 1'b1, 6'd32);
    rx_id = 32'h0000_5A5A;
    ind_mode = 1'b1;
    @(negedge clk);
    check(8, "idle hold 1", 1'b0, 1'b1, 6'd32);
    rx_id = 32'h4000_0000;
    @(negedge clk);
    check(8, "idle hold 2", 1'b0, 1'b1, 6'd32);

    // R8: back-to-back strobes each produce their own result
    ind_mode = 1'b0;
    rx_id    = 32'h0300_5A5A;
    rx_valid = 1'b1;
    @(negedge clk);
    check(8, "b2b first", 1'b1, 1'b1, 6'd3);
    rx_id = 32'h4000_5A5A;
    @(negedge clk);
    check(8, "b2b second", 1'b1, 1'b0, 6'd0);
    rx_valid = 1'b0;
    @(negedge clk);
    check(8, "b2b idle", 1'b0, 1'b0, 6'd0);

    // R3: narrowed common mask lets top byte alone decide
    glob_mask = 32'hFF00_0000;
    strobe(1'b0, ALL, 32'h2B00_0000);
    check(3, "narrow common mask", 1'b1, 1'b1, 6'd43);

    // R5: common mask of zero ignored in per-buffer scheme
    glob_mask = 32'h0000_0000;
    strobe(1'b1, ALL, 32'h4000_5A5A);
    check(5, "common mask ignored", 1'b1, 1'b0, 6'd0);

    // R5: dedicated masks ignored in per-buffer scheme
    ded_mask_a = 32'h0;
    ded_mask_b = 32'h0;
    strobe(1'b1, ALL, 32'h5555_5555);
    check(5, "dedicated masks ignored", 1'b1, 1'b0, 6'd0);

    // R4: dedicated mask of zero makes buffer 14 accept anything in shared scheme
    glob_mask = 32'hFFFF_FFFF;
    strobe(1'b0, ALL, 32'h5555_5555);
    check(4, "buffer 14 open", 1'b1, 1'b1, 6'd14);

    // R1: reset in mid-run clears held result
    rst_n = 1'b0;
    @(negedge clk);
    check(1, "mid-run reset", 1'b0, 1'b0, 6'd0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog: actual not finished expected finished");
      summary();
      $finish;
    end
  end

endmodule